// File: doc/BRIEF.md
# Wait/Hold Domain Clock Divider

This block divides a clock domain's source clock by an integer ratio between 2 and 2^(N+1), where N is the width of each count field (4 by default, 3 for the narrower memory-domain variant). The output spends a programmable number of source cycles high (the wait phase) and another programmable number low (the hold phase). Together they give a period of wait + hold + 2 source cycles. For a target ratio R, software programs wait = floor(R/2) - 1 and hold = R - wait - 2, which gives the duty cycle closest to half.

Software controls the block through a single configuration word that it writes and reads back. The word holds both counts, a bypass bit that passes the source clock straight through, and an update-request bit. New counts are held pending until the running period finishes. They are then committed together and the hardware clears the request bit, so software polls that bit to learn that the new ratio is in effect.

Top module: `ckdiv_wait_hold`

## Requirements
- R1: While and after reset the word reads back as zero (bypass off, no update pending, both counts 0), and the output starts high in a divide-by-2 pattern.
- R2: Outside bypass the output is high for wait+1 source cycles and then low for hold+1 source cycles, repeating with a period of wait+hold+2. This holds from the minimum ratio 2 up to the maximum 2^(N+1).
- R3: The wait count is at bits 19:16 and the hold count at bits 23:20 of the word. Readback returns the written counts in place, and every bit outside the counts, bypass (bit 24) and update (bit 25) reads 0.
- R4: When bit 24 is 1, the output equals the source clock.
- R5: Writing bit 25 as 1 sets the update request, which reads back as 1 while pending. A later write with bit 25 at 0 does not cancel it. Only the hardware clears it, in the cycle after the new counts are committed.
- R6: Written counts change the output only when an update is pending, and only at the end of a complete low phase. A write without bit 25 leaves the running ratio unchanged.
- R7: When bypass is turned off, the source cycle right after the capturing edge starts a fresh high (wait) phase.
- R8: While bypass is on, a pending update commits at the next source edge, so bit 25 reads 0 one cycle after it was seen as 1.
- R9: With a field width N, count bits above N are discarded on write and read as 0, so the maximum ratio is 2^(N+1). With N=3, a word with both counts written as 15 gives 8 cycles high and 8 cycles low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock of the domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes wr_data into the configuration word at the next rising edge |
| wr_data | input | CFG_W | Configuration word to write |
| rd_data | output | CFG_W | Readback of the configuration word |
| div_clk | output | 1 | Divided clock, or the source clock in bypass |

## Verification
A write presented before a rising edge is captured on that edge, so its fields and the update bit appear on the readback one cycle later. The divided output also reflects the edge's new phase in that same following cycle, because it comes straight from the phase flop. A commit lands on the edge that closes a low phase, and the update bit reads 0 in the cycle after that edge. The bench drives inputs on falling edges and advances its reference model on every rising edge. It compares the output and the readback 2 ns after each rising edge, while the source clock is high. It compares the output again 2 ns after each falling edge, which separates bypass (output low) from a divided phase.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int CKD_WAIT_LSB = 16;
  localparam int CKD_HOLD_LSB = 20;
  localparam int CKD_BYP_POS  = 24;
  localparam int CKD_UPD_POS  = 25;
  localparam int CKD_MIN_CFG_W = CKD_UPD_POS + 1;

  // full output period in source cycles for a pair of counts
  function automatic int unsigned ckd_period(input int unsigned w, input int unsigned h);
    return w + h + 2;
  endfunction
endpackage

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg
  import ckdiv_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int CFG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  input  logic               commit,
  output logic [FIELD_W-1:0] pend_wait,
  output logic [FIELD_W-1:0] pend_hold,
  output logic               byp_q,
  output logic               upd_q,
  output logic [CFG_W-1:0]   rd_data
);
  // bits of the written word that are not stored are reduced here
  logic wr_unused;
  assign wr_unused = ^wr_data;

  function automatic logic [FIELD_W-1:0] field_at(input logic [CFG_W-1:0] w, input int lsb);
    return w[lsb +: FIELD_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wait <= '0;
      pend_hold <= '0;
      byp_q     <= 1'b0;
    end else if (wr_en) begin
      pend_wait <= field_at(wr_data, CKD_WAIT_LSB);
      pend_hold <= field_at(wr_data, CKD_HOLD_LSB);
      byp_q     <= wr_data[CKD_BYP_POS];
    end
  end

  // request is set by software only and cleared by hardware only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      upd_q <= 1'b0;
    else if (wr_en && wr_data[CKD_UPD_POS])
      upd_q <= 1'b1;
    else if (commit)
      upd_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    rd_data[CKD_WAIT_LSB +: FIELD_W] = pend_wait;
    rd_data[CKD_HOLD_LSB +: FIELD_W] = pend_hold;
    rd_data[CKD_BYP_POS]             = byp_q;
    rd_data[CKD_UPD_POS]             = upd_q;
  end
endmodule

// File: rtl/ckdiv_phase.sv
module ckdiv_phase #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byp,
  input  logic               upd,
  input  logic [FIELD_W-1:0] pend_wait,
  input  logic [FIELD_W-1:0] pend_hold,
  output logic               div_q,
  output logic               period_end,
  output logic               commit,
  output logic [FIELD_W-1:0] act_wait,
  output logic [FIELD_W-1:0] act_hold
);
  logic [FIELD_W-1:0] cnt_q;
  logic wait_done;
  logic hold_done;

  function automatic logic phase_over(input logic [FIELD_W-1:0] c, input logic [FIELD_W-1:0] lim);
    return c == lim;
  endfunction

  assign wait_done  = div_q && phase_over(cnt_q, act_wait);
  assign hold_done  = !div_q && phase_over(cnt_q, act_hold);
  assign period_end = !byp && hold_done;
  assign commit     = upd && (byp || period_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_wait <= '0;
      act_hold <= '0;
    end else if (commit) begin
      act_wait <= pend_wait;
      act_hold <= pend_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b1;
      cnt_q <= '0;
    end else if (byp) begin
      div_q <= 1'b1;
      cnt_q <= '0;
    end else if (wait_done) begin
      div_q <= 1'b0;
      cnt_q <= '0;
    end else if (hold_done) begin
      div_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ckdiv_wait_hold.sv
module ckdiv_wait_hold
  import ckdiv_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int CFG_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             div_clk
);
  logic [FIELD_W-1:0] pend_wait;
  logic [FIELD_W-1:0] pend_hold;
  logic [FIELD_W-1:0] act_wait;
  logic [FIELD_W-1:0] act_hold;
  logic byp_q;
  logic upd_q;
  logic div_q;
  logic period_end;
  logic commit;

  ckdiv_cfg #(.FIELD_W(FIELD_W), .CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .commit    (commit),
    .pend_wait (pend_wait),
    .pend_hold (pend_hold),
    .byp_q     (byp_q),
    .upd_q     (upd_q),
    .rd_data   (rd_data)
  );

  ckdiv_phase #(.FIELD_W(FIELD_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .byp        (byp_q),
    .upd        (upd_q),
    .pend_wait  (pend_wait),
    .pend_hold  (pend_hold),
    .div_q      (div_q),
    .period_end (period_end),
    .commit     (commit),
    .act_wait   (act_wait),
    .act_hold   (act_hold)
  );

  assign div_clk = byp_q ? clk : div_q;
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
  parameter int FIELD_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               byp,
  input logic               upd,
  input logic               upd_wr,
  input logic               commit,
  input logic               period_end,
  input logic               div_q,
  input logic [FIELD_W-1:0] act_wait,
  input logic [FIELD_W-1:0] act_hold
);
  logic [FIELD_W:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_run <= '0;
    else if (byp || !div_q)
      hi_run <= '0;
    else
      hi_run <= hi_run + 1'b1;
  end

  // R5
  upd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !commit |=> upd);

  // R5
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !upd_wr |=> !upd);

  // R6
  commit_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (period_end || byp));

  // R6
  act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_wait) && $stable(act_hold));

  // R7
  leave_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byp) |-> div_q);

  // R2
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byp && !$past(byp) && !div_q && $past(div_q) |-> hi_run == {1'b0, act_wait} + 1'b1);

  // R2
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> !div_q && act_hold == $past(act_hold));
endmodule

bind ckdiv_wait_hold ckdiv_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byp        (byp_q),
  .upd        (upd_q),
  .upd_wr     (wr_en && wr_data[ckdiv_pkg::CKD_UPD_POS]),
  .commit     (commit),
  .period_end (period_end),
  .div_q      (div_q),
  .act_wait   (act_wait),
  .act_hold   (act_hold)
);

// File: tb/sim_ckdiv_wait_hold.sv
`timescale 1ns/1ps
module sim_ckdiv_wait_hold;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        div_clk;
  logic        wr1_en = 1'b0;
  logic [31:0] wr1_data = '0;
  logic [31:0] rd1;
  logic        div1;

  always #4 clk = ~clk;

  ckdiv_wait_hold u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                      .rd_data(rd_data), .div_clk(div_clk));
  ckdiv_wait_hold #(.FIELD_W(3)) u1 (.clk(clk), .rst_n(rst_n), .wr_en(wr1_en), .wr_data(wr1_data),
                      .rd_data(rd1), .div_clk(div1));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit model_on = 0;
  string tag = "R1";

  // reference model state: pending/active counts and position inside the period
  int m_pw = 0, m_ph = 0, m_aw = 0, m_ah = 0, m_pos = 0;
  bit m_byp = 0, m_upd = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word(input int w, input int h, input bit b, input bit u);
    return (32'(u) << 25) | (32'(b) << 24) | (32'(h & 15) << 20) | (32'(w & 15) << 16);
  endfunction

  function automatic logic [31:0] model_rd();
    return word(m_pw, m_ph, m_byp, m_upd);
  endfunction

  function automatic bit model_high();
    return m_pos <= m_aw;
  endfunction

  always begin
    @(posedge clk);
    if (model_on) begin
      if (m_byp) begin
        if (m_upd) begin m_aw = m_pw; m_ah = m_ph; m_upd = 0; end
        m_pos = 0;
      end else if (m_pos == m_aw + m_ah + 1) begin
        m_pos = 0;
        if (m_upd) begin m_aw = m_pw; m_ah = m_ph; m_upd = 0; end
      end else begin
        m_pos++;
      end
      if (wr_en) begin
        m_pw = int'(wr_data[19:16]);
        m_ph = int'(wr_data[23:20]);
        m_byp = wr_data[24];
        if (wr_data[25]) m_upd = 1;
      end
    end
    #2;
    if (model_on) begin
      check(div_clk == (m_byp ? 1'b1 : model_high()), m_byp ? "R4" : tag, 32'(div_clk), 32'(m_byp ? 1'b1 : model_high()));
      check(rd_data == model_rd(), {tag, " R3"}, rd_data, model_rd());
    end
    #4;
    if (model_on)
      check(div_clk == (m_byp ? 1'b0 : model_high()), m_byp ? "R4" : tag, 32'(div_clk), 32'(m_byp ? 1'b0 : model_high()));
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_commit(input string req);
    for (int i = 0; i < 80 && rd_data[25]; i++) @(negedge clk);
    check(rd_data[25] == 1'b0, req, 32'(rd_data[25]), 32'd0);
  endtask

  initial begin
    idle(3);
    // R1: reset state seen at the ports
    check(rd_data == 32'd0, "R1", rd_data, 32'd0);
    check(div_clk == 1'b1, "R1", 32'(div_clk), 32'd1);
    rst_n = 1'b1;
    model_on = 1;
    idle(12);

    // R2 and R5: ratio 6 (wait 3, hold 1)
    tag = "R2";
    wr(word(3, 1, 0, 1));
    check(rd_data[25] == 1'b1, "R5", 32'(rd_data[25]), 32'd1);
    wait_commit("R5");
    idle(30);

    // R6: counts without the update bit change nothing
    tag = "R6";
    wr(word(5, 2, 0, 0));
    check(rd_data[25] == 1'b0, "R6", 32'(rd_data[25]), 32'd0);
    idle(25);
    wr(word(5, 2, 0, 1));
    wait_commit("R6");
    idle(30);

    // R5: a later write without bit 25 does not cancel the request
    tag = "R5";
    wr(word(2, 3, 0, 1));
    wr(word(2, 3, 0, 0));
    check(rd_data[25] == 1'b1, "R5", 32'(rd_data[25]), 32'd1);
    wait_commit("R5");
    idle(30);

    // R2: largest ratio 32
    tag = "R2";
    wr(word(15, 15, 0, 1));
    wait_commit("R2");
    idle(90);

    // R4 and R8: bypass, then an update committed while bypassed
    tag = "R4";
    wr(word(15, 15, 1, 0));
    idle(6);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = word(1, 0, 1, 1);
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data[25] == 1'b1, "R8", 32'(rd_data[25]), 32'd1);
    @(negedge clk);
    check(rd_data[25] == 1'b0, "R8", 32'(rd_data[25]), 32'd0);
    idle(5);

    // R7: leaving bypass starts a high phase
    tag = "R7";
    wr(word(1, 0, 0, 0));
    check(div_clk == 1'b1, "R7", 32'(div_clk), 32'd1);
    idle(20);

    // R2: back to the minimum ratio
    tag = "R2";
    wr(word(0, 0, 0, 1));
    wait_commit("R2");
    idle(12);

    // R9: narrow variant drops the top count bit
    @(negedge clk);
    wr1_en = 1'b1;
    wr1_data = 32'h02FF_0000;
    @(negedge clk);
    wr1_en = 1'b0;
    check(rd1 == 32'h0277_0000, "R9", rd1, 32'h0277_0000);
    for (int i = 0; i < 80 && rd1[25]; i++) @(negedge clk);
    check(rd1[25] == 1'b0, "R9", 32'(rd1[25]), 32'd0);
    for (int i = 0; i < 40 && !(div1 == 1'b0); i++) @(negedge clk);
    for (int i = 0; i < 40 && !(div1 == 1'b1); i++) @(negedge clk);
    begin
      int hi_n = 0;
      int lo_n = 0;
      while (div1 == 1'b1 && hi_n < 40) begin hi_n++; @(negedge clk); end
      while (div1 == 1'b0 && lo_n < 40) begin lo_n++; @(negedge clk); end
      check(hi_n == 8, "R9", 32'(hi_n), 32'd8);
      check(lo_n == 8, "R9", 32'(lo_n), 32'd8);
    end

    model_on = 0;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule